// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execution Unit

This unit carries out the 256 second-byte instructions that follow a prefix byte in an 8-bit CPU. The top two opcode bits pick the group: shift/rotate/swap, bit-test, bit-reset or bit-set. The middle three bits pick the shift kind or the bit index. The low three bits pick the operand. Seven operand codes name registers. Code 6 names the byte in memory at the address held in the HL pair.

The sequencer pulses `start` together with the opcode during the prefix M-cycle, and each M-cycle lasts one clock. The unit latches the opcode and the incoming flags, then walks through the opcode cycle. For the memory operand it goes on to a read cycle and, when the instruction changes the byte, a write cycle. The total cycle count is shown on `mcycles`. The last cycle of every instruction is marked by `done`, and the computed byte and flags are valid in that cycle.

Flags are packed as [3]=Z, [2]=N, [1]=H, [0]=C on both `flags_in` and `flags_out`.

Top module: `bitop_unit`

## Requirements
- R1: Opcode bits [2:0] select the operand (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory at HL, 7 A). For a register operand, `reg_sel` equals opcode[2:0], and `reg_we` pulses only in the final cycle of a non-test instruction.
- R2: A register-operand instruction takes 2 M-cycles. `done` is high in the cycle after `start`, `mcycles` reads 2, and there is no memory access.
- R3: A bit-test on the memory operand takes 3 M-cycles. `mem_rd` and `done` are both high in the second cycle after `start`, `mem_wr` never rises, and `mcycles` reads 3.
- R4: Every other memory-operand instruction takes 4 M-cycles. `mem_rd` is high in the second cycle after `start`. `mem_wr` and `done` are high in the third cycle, with `result` holding the modified byte. `mcycles` reads 4.
- R5: Opcodes 0x00–0x3F use bits [5:3] to select the operation: 0 RLC, 1 RRC, 2 RL, 3 RR, 4 SLA, 5 SRA, 6 SWAP, 7 SRL. RL and RR rotate through the incoming C. RLC and RRC copy the end bit into the opposite end. SRA keeps bit 7. SLA and SRL shift in zero.
- R6: The shift group sets Z when the result is zero and clears N and H. C takes the bit shifted out, except that SWAP clears C.
- R7: Opcodes 0x40–0x7F test bit [5:3] of the operand. Z is set to the inverse of that bit, N is cleared, H is set and C is kept. Nothing is written.
- R8: Opcodes 0x80–0xBF clear bit [5:3] of the operand and opcodes 0xC0–0xFF set it. The flags are returned unchanged.
- R9: A `start` that arrives while an instruction is in progress is ignored and produces no extra `done`.
- R10: After reset the unit is idle, and `done`, `reg_we`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one M-cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction start, high during the prefix cycle |
| opcode | input | 8 | Second opcode byte, valid with start |
| reg_rdata | input | 8 | Register-file value of the selected register |
| mem_rdata | input | 8 | Memory read data during the read cycle |
| flags_in | input | 4 | Incoming Z,N,H,C |
| result | output | 8 | Computed byte, used for register or memory write |
| flags_out | output | 4 | Updated Z,N,H,C, valid with done |
| reg_sel | output | 3 | Operand register index |
| reg_we | output | 1 | Register write enable |
| mem_rd | output | 1 | Memory read request at HL |
| mem_wr | output | 1 | Memory write request at HL |
| done | output | 1 | Final-cycle pulse |
| mcycles | output | 3 | Total M-cycle count of the current instruction |

## Verification
Every one of the 256 opcodes is run with five operand bytes, and the incoming carry alternates between runs. The byte 0x00 shows whether Z is produced. The bytes 0x80 and 0x01 separate the four rotate kinds and the arithmetic shift from the logical shift, and also show which end feeds C. The byte 0xF0 distinguishes SWAP from the shifts. The byte 0xA5 gives each bit index a different tested value. A second `start` issued in the middle of memory instructions checks that the latched opcode is kept and that no stray completion appears.

// File: rtl/bitop_unit.sv
module bitop_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] opcode,
  input  logic [7:0] reg_rdata,
  input  logic [7:0] mem_rdata,
  input  logic [3:0] flags_in,
  output logic [7:0] result,
  output logic [3:0] flags_out,
  output logic [2:0] reg_sel,
  output logic       reg_we,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       done,
  output logic [2:0] mcycles
);

  localparam logic [2:0] MEM_IDX = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_EXE, S_MRD, S_MWR} st_t;

  st_t        st;
  logic [7:0] op_q, mem_q, src;
  logic [3:0] fl_q;
  logic [8:0] sh;

  wire is_mem  = (op_q[2:0] == MEM_IDX);
  wire is_test = (op_q[7:6] == 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      op_q  <= '0;
      fl_q  <= '0;
      mem_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q <= opcode;
          fl_q <= flags_in;
          st   <= S_EXE;
        end
        S_EXE:   st <= is_mem ? S_MRD : S_IDLE;
        S_MRD: begin
          mem_q <= mem_rdata;
          st    <= is_test ? S_IDLE : S_MWR;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign src = (st == S_MWR) ? mem_q : (st == S_MRD) ? mem_rdata : reg_rdata;

  always_comb begin
    case (op_q[5:3])
      3'd0:    sh = {src[7], src[6:0], src[7]};
      3'd1:    sh = {src[0], src[0], src[7:1]};
      3'd2:    sh = {src[7], src[6:0], fl_q[0]};
      3'd3:    sh = {src[0], fl_q[0], src[7:1]};
      3'd4:    sh = {src[7], src[6:0], 1'b0};
      3'd5:    sh = {src[0], src[7], src[7:1]};
      3'd6:    sh = {1'b0, src[3:0], src[7:4]};
      default: sh = {src[0], 1'b0, src[7:1]};
    endcase
  end

  always_comb begin
    case (op_q[7:6])
      2'b00: begin
        result    = sh[7:0];
        flags_out = {sh[7:0] == 8'h00, 2'b00, sh[8]};
      end
      2'b01: begin
        result    = src;
        flags_out = {~src[op_q[5:3]], 1'b0, 1'b1, fl_q[0]};
      end
      2'b10: begin
        result    = src & ~(8'h01 << op_q[5:3]);
        flags_out = fl_q;
      end
      default: begin
        result    = src | (8'h01 << op_q[5:3]);
        flags_out = fl_q;
      end
    endcase
  end

  assign reg_sel = op_q[2:0];
  assign reg_we  = (st == S_EXE) && !is_mem && !is_test;
  assign mem_rd  = (st == S_MRD);
  assign mem_wr  = (st == S_MWR);
  assign done    = ((st == S_EXE) && !is_mem) || ((st == S_MRD) && is_test) || (st == S_MWR);
  assign mcycles = !is_mem ? 3'd2 : is_test ? 3'd3 : 3'd4;

  // R4
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));

  // R3
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && is_test) |=> !mem_wr);

  // R2
  reg_form_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && opcode[2:0] != MEM_IDX) |=> (done && !mem_rd && !mem_wr));

  // R1
  reg_we_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (done && !mem_rd && !mem_wr));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(op_q));

  // R7
  test_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_test) |-> (flags_out[1] && !flags_out[2] && flags_out[0] == fl_q[0] && !reg_we));

endmodule

// File: tb/bitop_unit_tb.sv
`timescale 1ns/1ps
module bitop_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] opcode = '0, reg_rdata = '0, mem_rdata = '0;
  logic [3:0] flags_in = '0;
  logic [7:0] result;
  logic [3:0] flags_out;
  logic [2:0] reg_sel, mcycles;
  logic       reg_we, mem_rd, mem_wr, done;

  always #2 clk = ~clk;

  bitop_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .reg_rdata(reg_rdata), .mem_rdata(mem_rdata), .flags_in(flags_in),
    .result(result), .flags_out(flags_out), .reg_sel(reg_sel),
    .reg_we(reg_we), .mem_rd(mem_rd), .mem_wr(mem_wr), .done(done),
    .mcycles(mcycles)
  );

  typedef struct {
    logic [7:0] op;
    logic [7:0] res;
    logic [3:0] fl;
    logic       rwe;
    int         mc;
    int         t0;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0, cyc = 0, rd_cnt = 0, wr_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic exp_t model(input logic [7:0] op, input logic [7:0] d, input logic [3:0] f);
    exp_t       e;
    logic [8:0] w;
    int         k = int'(op[5:3]);
    logic       c = f[0];
    e.op  = op;
    e.mc  = (op[2:0] != 3'd6) ? 2 : (op[7:6] == 2'b01) ? 3 : 4;
    e.rwe = (op[2:0] != 3'd6) && (op[7:6] != 2'b01);
    e.res = d;
    e.fl  = f;
    e.t0  = 0;
    case (op[7:6])
      2'b00: begin
        case (k)
          0: w = {d, d[7]};
          1: w = {d[0], d[0], d[7:1]};
          2: w = {d, c};
          3: w = {d[0], c, d[7:1]};
          4: w = {d, 1'b0};
          5: w = {d[0], d[7], d[7:1]};
          6: w = {1'b0, d[3:0], d[7:4]};
          default: w = {d[0], 1'b0, d[7:1]};
        endcase
        e.res = w[7:0];
        e.fl  = {(w[7:0] == 8'h00), 1'b0, 1'b0, w[8]};
      end
      2'b01: e.fl = {~d[k], 1'b0, 1'b1, c};
      2'b10: e.res = d & ~(8'h01 << k);
      default: e.res = d | (8'h01 << k);
    endcase
    return e;
  endfunction

  task automatic run(input logic [7:0] op, input logic [7:0] rv, input logic [7:0] mv,
                     input logic [3:0] fl, input bit poke);
    exp_t e;
    @(negedge clk);
    opcode = op; reg_rdata = rv; mem_rdata = mv; flags_in = fl; start = 1'b1;
    e    = model(op, (op[2:0] == 3'd6) ? mv : rv, fl);
    e.t0 = cyc;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      opcode = ~op;
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
      opcode = op;
    end
    repeat (3) @(negedge clk);
  endtask

  // Monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t  e;
      string g;
      rd_cnt += int'(mem_rd);
      wr_cnt += int'(mem_wr);
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 stray done", 1, 0);
        end else begin
          e = q.pop_front();
          g = (e.op[7:6] == 2'b00) ? "R5/R6" : (e.op[7:6] == 2'b01) ? "R7" : "R8";
          chk(cyc - e.t0 + 1 == e.mc, (e.mc == 2) ? "R2 latency" : (e.mc == 3) ? "R3 latency" : "R4 latency",
              cyc - e.t0 + 1, e.mc);
          chk(int'(mcycles) == e.mc, "R2/R3/R4 mcycles", mcycles, e.mc);
          chk(reg_we == e.rwe, "R1 reg_we", reg_we, e.rwe);
          chk(rd_cnt == ((e.mc > 2) ? 1 : 0), "R3 mem_rd count", rd_cnt, (e.mc > 2) ? 1 : 0);
          chk(wr_cnt == ((e.mc == 4) ? 1 : 0), "R4 mem_wr count", wr_cnt, (e.mc == 4) ? 1 : 0);
          chk(flags_out == e.fl, {g, " flags"}, flags_out, e.fl);
          if (e.rwe) begin
            chk(reg_sel == e.op[2:0], "R1 reg_sel", reg_sel, e.op[2:0]);
            chk(result == e.res, {g, " reg result"}, result, e.res);
          end
          if (e.mc == 4) begin
            chk(mem_wr == 1'b1, "R4 write in final cycle", mem_wr, 1);
            chk(result == e.res, {g, " R4 mem result"}, result, e.res);
          end
        end
        rd_cnt = 0;
        wr_cnt = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pat [5];
    pat[0] = 8'h00; pat[1] = 8'h80; pat[2] = 8'h01; pat[3] = 8'hF0; pat[4] = 8'hA5;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!done && !reg_we && !mem_rd && !mem_wr, "R10 reset outputs", {done, reg_we, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !reg_we && !mem_rd && !mem_wr, "R10 idle after reset", {done, reg_we, mem_rd, mem_wr}, 0);

    // Directed corners: R5 R6 R7 R8
    run(8'h00, 8'h80, 8'h00, 4'b0000, 1'b0); // RLC B: 0x01, C=1
    run(8'h2F, 8'h81, 8'h00, 4'b0000, 1'b0); // SRA A: 0xC0, C=1
    run(8'h37, 8'hF0, 8'h00, 4'b0001, 1'b0); // SWAP A clears C
    run(8'h11, 8'h80, 8'h00, 4'b0000, 1'b0); // RL C: zero result, Z=1
    run(8'h1E, 8'h00, 8'h01, 4'b0001, 1'b0); // RR (HL) with C in
    run(8'h7E, 8'h00, 8'h7F, 4'b1110, 1'b0); // BIT 7,(HL): Z=1
    run(8'hBE, 8'h00, 8'hFF, 4'b1010, 1'b0); // RES 7,(HL)
    run(8'hC7, 8'h00, 8'h00, 4'b0101, 1'b0); // SET 0,A

    // Exhaustive sweep
    for (int op = 0; op < 256; op++)
      for (int p = 0; p < 5; p++)
        run(op[7:0], pat[p], pat[(p + 2) % 5], {2'b00, p[0], op[0] ^ p[1]}, 1'b0);

    // R9: start while busy
    run(8'h06, 8'h00, 8'h81, 4'b0000, 1'b1);
    run(8'h46, 8'h00, 8'h01, 4'b0000, 1'b1);
    run(8'hFE, 8'h00, 8'h00, 4'b0000, 1'b1);
    repeat (8) @(negedge clk);
    chk(q.size() == 0, "R9 queue drained", q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule